// File: doc/BRIEF.md
# SDRAM Row Activation Scheduler

This block sits between a source of single memory requests and the command pins of a four-bank SDRAM. For each request (bank, row, column, read or write) it works out whether the target bank already has the wanted row open, is idle, or has a different row open. From that it issues a column command at once, opens the row first, or closes the old row and then opens the new one. It keeps a record of which banks are open and which row each holds. It spaces every command so that each minimum interval is met, with all intervals counted in whole clock cycles.

Every interval is given as a picosecond figure together with the clock period. At elaboration each is turned into a cycle count by rounding the quotient up. Each bank has its own timers for the open-to-column, open-to-open and close-to-open spacings. One shared timer spaces openings across different banks. Only one command is placed on the pins per clock, and every other clock carries a no-operation.

Requests arrive through a valid/ready handshake. The source raises `req_valid` and must hold every request field steady until it sees `req_ready` high at a clock edge. `req_ready` is raised only in the cycle in which the scheduler chooses the read or write for that request. Until then, cycles spent opening or closing rows act as back-pressure. `req_ready` depends on `req_valid` and is low whenever `req_valid` is low. Command pins are registered, so a command chosen in cycle n appears on the pins in cycle n+1.

Top module: `sdram_act_sched`

## Requirements
- R1: A READ or WRITE is issued only to a bank whose open row equals the request row. An ACTIVE is issued only to a closed bank, with the bank on `sd_ba` and the request row as its row.
- R2: Each cycle limit equals its picosecond value divided by the clock period, rounded up to a whole number; for example, 15000 ps at a 7000 ps clock gives 3.
- R3: A READ or WRITE comes no sooner than tRCD cycles after the ACTIVE to its bank. If the request is already waiting, it comes exactly then: ACTIVE at T0, NOP at T1 and T2, column command at T3 for tRCD = 3.
- R4: A request to the row already open in its bank, with tRCD already met, is accepted in the cycle it is presented, with no new ACTIVE.
- R5: A request to a bank holding a different row first causes a PRECHARGE of that bank (A10 low), in the cycle after it is presented. This is followed by an ACTIVE and then the column command.
- R6: Two ACTIVE commands to the same bank are at least tRC cycles apart. A waiting ACTIVE is issued on the first cycle in which tRC, tRP and tRRD all allow it.
- R7: An ACTIVE to a bank comes at least tRP cycles after the PRECHARGE of that bank.
- R8: ACTIVE commands to different banks are at least tRRD cycles apart.
- R9: Pin encodings as {cs_n, ras_n, cas_n, we_n}: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, NOP 0111. No other value is driven.
- R10: In reset, and in every cycle after a cycle with `req_valid` low, the pins carry NOP. `req_ready` is low in reset.
- R11: `req_ready` is high only in the cycle the column command for the presented request is chosen. That command, for the same bank, column and direction, appears on the pins in the next cycle.
- R12: During ACTIVE, `sd_addr` carries the row. During READ or WRITE it carries the zero-extended column, with A10 low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed row/column address |

## Verification
A request presented in cycle p causes its first command on the pins in cycle p+1. An accepted request shows its column command in the cycle after the handshake. An ACTIVE shown in cycle a allows the column command no sooner than cycle a+tRCD. The bench samples the pins on the falling edge and counts cycles on the rising edge, so each command is tied to the cycle in which it became visible. The bench compares each ACTIVE, PRECHARGE and column command against these offsets. It also checks each ACTIVE against the largest of its three waiting bounds, computed from its own record of earlier commands.

// File: rtl/sdram_act_pkg.sv
package sdram_act_pkg;

  // pin order {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  // interval in picoseconds to whole clocks, rounding up
  function automatic int unsigned ps_to_clk(input int unsigned spec_ps,
                                            input int unsigned period_ps);
    return (spec_ps + period_ps - 1) / period_ps;
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic met
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] RELOAD = (LIMIT > 0) ? CW'(LIMIT - 1) : '0;

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= '0;
    else if (fire)            remain <= RELOAD;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign met = (remain == '0);

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int unsigned ROW_W   = 13,
  parameter int unsigned TRCD_CK = 3,
  parameter int unsigned TRC_CK  = 9,
  parameter int unsigned TRP_CK  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic             pre_fire,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             col_ok,
  output logic             act_ok
);
  logic rc_met, rp_met;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open  <= 1'b0;
      open_row <= '0;
    end else if (act_fire) begin
      is_open  <= 1'b1;
      open_row <= act_row;
    end else if (pre_fire) begin
      is_open  <= 1'b0;
    end
  end

  sdram_gap_timer #(.LIMIT(TRCD_CK)) u_rcd (
    .clk(clk), .rst_n(rst_n), .fire(act_fire), .met(col_ok));

  sdram_gap_timer #(.LIMIT(TRC_CK)) u_rc (
    .clk(clk), .rst_n(rst_n), .fire(act_fire), .met(rc_met));

  sdram_gap_timer #(.LIMIT(TRP_CK)) u_rp (
    .clk(clk), .rst_n(rst_n), .fire(pre_fire), .met(rp_met));

  assign act_ok = rc_met && rp_met;

endmodule

// File: rtl/sdram_cmd_pick.sv
module sdram_cmd_pick
  import sdram_act_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 13,
  parameter int unsigned COL_W  = 9,
  localparam int unsigned NBANK = 1 << BANK_W
) (
  input  logic                        req_valid,
  input  logic [BANK_W-1:0]           req_bank,
  input  logic [ROW_W-1:0]            req_row,
  input  logic [COL_W-1:0]            req_col,
  input  logic                        req_write,
  input  logic [NBANK-1:0]            bank_open,
  input  logic [NBANK-1:0][ROW_W-1:0] bank_row,
  input  logic [NBANK-1:0]            bank_col_ok,
  input  logic [NBANK-1:0]            bank_act_ok,
  input  logic                        rrd_met,
  output sd_cmd_e                     cmd,
  output logic [ROW_W-1:0]            cmd_addr,
  output logic                        accept,
  output logic [NBANK-1:0]            act_fire,
  output logic [NBANK-1:0]            pre_fire
);
  logic row_hit;
  assign row_hit = bank_open[req_bank] && (bank_row[req_bank] == req_row);

  always_comb begin
    cmd      = CMD_NOP;
    cmd_addr = '0;
    accept   = 1'b0;
    act_fire = '0;
    pre_fire = '0;
    if (req_valid) begin
      if (row_hit) begin
        if (bank_col_ok[req_bank]) begin
          cmd      = req_write ? CMD_WR : CMD_RD;
          cmd_addr = ROW_W'(req_col);
          accept   = 1'b1;
        end
      end else if (bank_open[req_bank]) begin
        cmd                = CMD_PRE;
        pre_fire[req_bank] = 1'b1;
      end else if (bank_act_ok[req_bank] && rrd_met) begin
        cmd                = CMD_ACT;
        cmd_addr           = req_row;
        act_fire[req_bank] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdram_act_sched.sv
module sdram_act_sched
  import sdram_act_pkg::*;
#(
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned ROW_W   = 13,
  parameter int unsigned COL_W   = 9,
  parameter int unsigned CLK_PS  = 7000,
  parameter int unsigned TRCD_PS = 15000,
  parameter int unsigned TRC_PS  = 60000,
  parameter int unsigned TRRD_PS = 14000,
  parameter int unsigned TRP_PS  = 15000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr
);
  localparam int unsigned NBANK   = 1 << BANK_W;
  localparam int unsigned TRCD_CK = ps_to_clk(TRCD_PS, CLK_PS);
  localparam int unsigned TRC_CK  = ps_to_clk(TRC_PS, CLK_PS);
  localparam int unsigned TRRD_CK = ps_to_clk(TRRD_PS, CLK_PS);
  localparam int unsigned TRP_CK  = ps_to_clk(TRP_PS, CLK_PS);

  logic [NBANK-1:0]            b_open, b_col_ok, b_act_ok;
  logic [NBANK-1:0][ROW_W-1:0] b_row;
  logic [NBANK-1:0]            act_fire, pre_fire;
  logic                        rrd_met;
  sd_cmd_e                     pick_cmd;
  logic [ROW_W-1:0]            pick_addr;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdram_bank_track #(
      .ROW_W(ROW_W), .TRCD_CK(TRCD_CK), .TRC_CK(TRC_CK), .TRP_CK(TRP_CK)
    ) u_track (
      .clk(clk), .rst_n(rst_n),
      .act_fire(act_fire[g]), .pre_fire(pre_fire[g]), .act_row(req_row),
      .is_open(b_open[g]), .open_row(b_row[g]),
      .col_ok(b_col_ok[g]), .act_ok(b_act_ok[g])
    );
  end

  sdram_gap_timer #(.LIMIT(TRRD_CK)) u_rrd (
    .clk(clk), .rst_n(rst_n), .fire(|act_fire), .met(rrd_met));

  sdram_cmd_pick #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_pick (
    .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_write(req_write),
    .bank_open(b_open), .bank_row(b_row),
    .bank_col_ok(b_col_ok), .bank_act_ok(b_act_ok), .rrd_met(rrd_met),
    .cmd(pick_cmd), .cmd_addr(pick_addr), .accept(req_ready),
    .act_fire(act_fire), .pre_fire(pre_fire)
  );

  sd_cmd_e           cmd_q;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cmd_q  <= pick_cmd;
      ba_q   <= (pick_cmd == CMD_NOP) ? '0 : req_bank;
      addr_q <= pick_addr;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba   = ba_q;
  assign sd_addr = addr_q;

endmodule

// File: rtl/sdram_act_sched_chk.sv
module sdram_act_sched_chk
  import sdram_act_pkg::*;
#(
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned TRCD_CK = 3,
  parameter int unsigned TRC_CK  = 9,
  parameter int unsigned TRRD_CK = 2,
  parameter int unsigned TRP_CK  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BANK_W-1:0] sd_ba
);
  localparam int unsigned NB   = 1 << BANK_W;
  localparam int unsigned M1   = (TRCD_CK > TRC_CK) ? TRCD_CK : TRC_CK;
  localparam int unsigned M2   = (TRRD_CK > TRP_CK) ? TRRD_CK : TRP_CK;
  localparam int unsigned MAXL = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW   = $clog2(MAXL + 2);
  localparam logic [CW-1:0] SAT = '1;

  logic [3:0] pins;
  logic is_act, is_pre, is_col, is_nop;
  assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act = (pins == 4'b0011);
  assign is_pre = (pins == 4'b0010);
  assign is_col = (pins == 4'b0101) || (pins == 4'b0100);
  assign is_nop = (pins == 4'b0111);

  logic [NB-1:0] sh_open;
  logic [CW-1:0] since_act [NB];
  logic [CW-1:0] since_pre [NB];
  logic [CW-1:0] since_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_open   <= '0;
      since_any <= SAT;
      for (int b = 0; b < NB; b++) begin
        since_act[b] <= SAT;
        since_pre[b] <= SAT;
      end
    end else begin
      since_any <= is_act ? CW'(1) : ((since_any == SAT) ? SAT : since_any + 1'b1);
      for (int b = 0; b < NB; b++) begin
        if (is_act && sd_ba == BANK_W'(b)) begin
          since_act[b] <= CW'(1);
          sh_open[b]   <= 1'b1;
        end else begin
          since_act[b] <= (since_act[b] == SAT) ? SAT : since_act[b] + 1'b1;
        end
        if (is_pre && sd_ba == BANK_W'(b)) begin
          since_pre[b] <= CW'(1);
          sh_open[b]   <= 1'b0;
        end else begin
          since_pre[b] <= (since_pre[b] == SAT) ? SAT : since_pre[b] + 1'b1;
        end
      end
    end
  end

  // R9
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act || is_pre || is_col || is_nop);

  // R1
  col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> sh_open[sd_ba]);

  // R1
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !sh_open[sd_ba]);

  // R5
  pre_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> sh_open[sd_ba]);

  // R3
  col_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_act[sd_ba] >= CW'(TRCD_CK));

  // R6
  act_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_act[sd_ba] >= CW'(TRC_CK));

  // R7
  act_rp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_pre[sd_ba] >= CW'(TRP_CK));

  // R8
  act_rrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_any >= CW'(TRRD_CK));

  // R11
  accept_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (is_col && sd_ba == $past(req_bank)));

  // R10
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> is_nop);

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ready);

endmodule

bind sdram_act_sched sdram_act_sched_chk #(
  .BANK_W(BANK_W), .TRCD_CK(TRCD_CK), .TRC_CK(TRC_CK),
  .TRRD_CK(TRRD_CK), .TRP_CK(TRP_CK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bank(req_bank), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba)
);

// File: tb/sdram_act_sched_test.sv
module sdram_act_sched_test;
  localparam int CLK_PS  = 7000;
  localparam int TRCD_PS = 15000;
  localparam int TRC_PS  = 70000;
  localparam int TRRD_PS = 30000;
  localparam int TRP_PS  = 18000;
  // bench-side ceilings
  localparam int TRCD_E = (TRCD_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRC_E  = (TRC_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRRD_E = (TRRD_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRP_E  = (TRP_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic req_write = 1'b0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;

  sdram_act_sched #(
    .BANK_W(2), .ROW_W(13), .COL_W(9), .CLK_PS(CLK_PS),
    .TRCD_PS(TRCD_PS), .TRC_PS(TRC_PS), .TRRD_PS(TRRD_PS), .TRP_PS(TRP_PS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench model of the command bus
  int  m_act [4], m_pre [4], m_row [4];
  bit  m_open [4];
  int  m_any = -1000, last_col = -1000;
  logic v_edge = 1'b0;
  logic [1:0] e_bank;
  logic [12:0] e_row;
  int qb [1024], qr [1024], qc [1024], qhs [1024];
  bit qw [1024];
  int qh = 0, qt = 0;
  int pres = 0, hs = 0;

  initial for (int i = 0; i < 4; i++) begin
    m_act[i] = -1000; m_pre[i] = -1000; m_row[i] = 0; m_open[i] = 0;
  end

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    v_edge <= req_valid;
    e_bank <= req_bank;
    e_row  <= req_row;
  end

  always @(negedge clk) begin
    logic [3:0] p;
    int b;
    p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    b = int'(sd_ba);
    if (!rst_n) begin
      chk(p == 4'b0111 && !req_ready, "R10 reset state NOP, ready low", int'(p), 7);
    end else begin
      chk(p inside {4'b0011, 4'b0101, 4'b0100, 4'b0010, 4'b0111},
          "R9 legal pin encoding", int'(p), 7);
      if (!v_edge) chk(p == 4'b0111, "R10 NOP after idle cycle", int'(p), 7);
      case (p)
        4'b0011: begin
          chk(!m_open[b], "R1 ACTIVE only to closed bank", int'(m_open[b]), 0);
          chk(cyc - m_pre[b] >= TRP_E, "R7 PRECHARGE to ACTIVE gap", cyc - m_pre[b], TRP_E);
          chk(cyc - m_act[b] >= TRC_E, "R6 same-bank ACTIVE gap", cyc - m_act[b], TRC_E);
          chk(cyc - m_any >= TRRD_E, "R8 cross-bank ACTIVE gap", cyc - m_any, TRRD_E);
          chk(sd_ba == e_bank, "R1 ACTIVE bank", b, int'(e_bank));
          chk(sd_addr == e_row, "R12 row on address", int'(sd_addr), int'(e_row));
          m_open[b] = 1; m_row[b] = int'(sd_addr); m_act[b] = cyc; m_any = cyc;
        end
        4'b0010: begin
          chk(m_open[b], "R5 PRECHARGE of open bank", int'(m_open[b]), 1);
          chk(sd_ba == e_bank, "R5 PRECHARGE bank", b, int'(e_bank));
          chk(sd_addr[10] == 1'b0, "R5 single-bank precharge A10", int'(sd_addr[10]), 0);
          m_open[b] = 0; m_pre[b] = cyc;
        end
        4'b0101, 4'b0100: begin
          if (qh == qt) begin
            chk(0, "R11 column command without handshake", cyc, -1);
          end else begin
            chk(b == qb[qh], "R11 column bank", b, qb[qh]);
            chk(int'(sd_addr) == qc[qh], "R12 column on address", int'(sd_addr), qc[qh]);
            chk((p == 4'b0100) == qw[qh], "R11 read/write direction", int'(p), qw[qh] ? 4 : 5);
            chk(cyc == qhs[qh] + 1, "R11 column one cycle after handshake", cyc, qhs[qh] + 1);
            chk(m_open[b] && m_row[b] == qr[qh], "R1 column to open matching row", m_row[b], qr[qh]);
            chk(cyc - m_act[b] >= TRCD_E, "R3 ACTIVE to column gap", cyc - m_act[b], TRCD_E);
            qh++;
          end
          last_col = cyc;
        end
        default: ;
      endcase
    end
  end

  task automatic send(input int b, input int r, input int c, input bit w);
    @(negedge clk);
    req_valid = 1'b1;
    req_bank  = 2'(b);
    req_row   = 13'(r);
    req_col   = 9'(c);
    req_write = w;
    pres = cyc;
    forever begin
      #2;
      if (req_ready) break;
      @(negedge clk);
    end
    hs = cyc;
    qb[qt] = b; qr[qt] = r; qc[qt] = c; qw[qt] = w; qhs[qt] = hs; qt++;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
    #3;
  endtask

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      nfail++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int pa, ha, acta, pb, hb, actb, pc, hc, prec, actc, exp_act, anyc;
    int pred, actd, acte1, acte2;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R2 rounding: 15000/7000 -> 3
    chk(TRCD_E == 3, "R2 ceiling of 2.14", TRCD_E, 3);

    // idle bank, then row hit, then row miss back to back on bank 0
    send(0, 5, 7, 1'b0);
    pa = pres; ha = hs; acta = m_act[0];
    send(0, 5, 9, 1'b1);
    pb = pres; hb = hs; actb = m_act[0];
    anyc = m_any;
    send(0, 6, 1, 1'b0);
    pc = pres; hc = hs; prec = m_pre[0]; actc = m_act[0];
    idle(2);
    chk(acta == pa + 1, "R1 idle bank opened at once", acta, pa + 1);
    chk(ha + 1 - acta == 3, "R2 three-cycle ACTIVE to READ", ha + 1 - acta, 3);
    chk(ha + 1 == acta + TRCD_E, "R3 column exactly tRCD after ACTIVE", ha + 1, acta + TRCD_E);
    chk(hb == pb, "R4 row hit accepted when presented", hb, pb);
    chk(actb == acta, "R4 row hit issues no ACTIVE", actb, acta);
    chk(prec == pc + 1, "R5 PRECHARGE right after miss", prec, pc + 1);
    exp_act = max3(prec + TRP_E, acta + TRC_E, anyc + TRRD_E);
    chk(actc == exp_act, "R6 reopen at earliest legal cycle", actc, exp_act);
    chk(acta + TRC_E > prec + TRP_E, "R6 tRC is the binding bound", acta + TRC_E, prec + TRP_E);
    chk(hc + 1 == actc + TRCD_E, "R3 column after reopen", hc + 1, actc + TRCD_E);

    // tRP binding on bank 3
    send(3, 2, 3, 1'b1);
    idle(20);
    send(3, 4, 5, 1'b0);
    pred = m_pre[3]; actd = m_act[3];
    idle(2);
    chk(actd == pred + TRP_E, "R7 ACTIVE exactly tRP after PRECHARGE", actd, pred + TRP_E);

    // tRRD binding across banks 1 and 2
    idle(20);
    send(1, 8191, 511, 1'b0);
    acte1 = m_act[1];
    send(2, 0, 0, 1'b1);
    acte2 = m_act[2];
    idle(2);
    chk(acte2 - acte1 == TRRD_E, "R8 second bank opened exactly tRRD later", acte2 - acte1, TRRD_E);

    // sweep of mixed hits, misses and idle banks
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      send(int'(lfsr[1:0]), lfsr[5] ? 8191 : int'(lfsr[4]), int'(lfsr[14:6]), lfsr[15]);
      if (lfsr[3:2] == 2'b00) idle(1);
    end
    idle(30);
    chk(qh == qt, "R11 every accepted request issued", qh, qt);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule